// File: doc/BRIEF.md
# Counted Reset Sequencer

This block produces the chip's internal reset from two sources: a power-good level and an active-low reset pin. Either source opens a reset window that lasts a fixed number of reference clock cycles. While the window is open, the pin is ignored. When the window closes, the pin can only start another reset after it has been seen high and then low again. A pin that is simply held low therefore cannot keep the chip in reset forever.

During the power-on window the block also samples the configuration pin and freezes its value. Downstream logic reads this value to tell whether it runs in hardwired (strap) mode or in register-programmed mode. The reference oscillator and the buffered master clock have no reset and lie outside this block.

Top module: `counted_reset_seq`

## Requirements
- R1: While `pwr_good` is low, `rst_int` is 1 at once, with no clock edge needed.
- R2: After `pwr_good` rises, `rst_int` falls on the `WINDOW`-th rising clock edge.
- R3: A falling edge on `rst_pin_n` passes through a two-stage synchronizer. `rst_int` rises on the third rising clock edge after the pin falls and then stays 1 for exactly `WINDOW` cycles.
- R4: Any toggling of `rst_pin_n` while `rst_int` is 1 neither lengthens nor restarts the window.
- R5: If `rst_pin_n` is still low when a window ends, no reset starts until the pin has been high and then falls again. This also holds for a pin held low through power-up.
- R6: `mode_hw` takes the value of `mode_pin` in the last cycle of the power-on window, where 1 means hardwired mode and 0 means register mode. It then holds that value, including across resets started by the pin. In reset, `mode_hw` is 0.
- R7: If `pwr_good` falls during a window started by the pin, a full power-on window starts when `pwr_good` returns, and the mode is sampled again.
- R8: A low pulse on `rst_pin_n` of a single clock cycle starts a full-length reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, free running |
| pwr_good | input | 1 | Supply-good level; low forces reset asynchronously |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous to `clk_ref` |
| mode_pin | input | 1 | Configuration pin, sampled during the power-on window |
| rst_int | output | 1 | Internal reset, active high |
| mode_hw | output | 1 | Frozen mode: 1 hardwired, 0 register programmed |

## Verification
The assertions assume that `pwr_good` is released away from a rising edge of `clk_ref`. The block does not synchronize that release. They also assume that `mode_pin` is steady when the power-on window closes. The reset pin itself may move at any time, because it is synchronized before use. The bench changes every input only on falling clock edges. It keeps `mode_pin` steady through each power-on window and changes it only once the window has closed, so a capture taken at the wrong time shows up as a wrong `mode_hw`.

// File: rtl/counted_reset_seq.sv
module counted_reset_seq #(
  parameter int WINDOW     = 1024,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk_ref,
  input  logic pwr_good,
  input  logic rst_pin_n,
  input  logic mode_pin,
  output logic rst_int,
  output logic mode_hw
);

  localparam int CW = $clog2(WINDOW);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic [CW-1:0]         cnt;
  logic                  busy;
  logic                  armed;
  logic                  por;
  logic                  mode_q;

  wire pin_s = sync_q[SYNC_DEPTH-1];
  wire last  = (cnt == LAST);

  always_ff @(posedge clk_ref or negedge pwr_good)
    if (!pwr_good) sync_q <= '1;
    else           sync_q <= {sync_q[SYNC_DEPTH-2:0], rst_pin_n};

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) begin
      busy   <= 1'b1;
      cnt    <= '0;
      armed  <= 1'b0;
      por    <= 1'b1;
      mode_q <= 1'b0;
    end else if (busy) begin
      armed <= 1'b0;
      if (por) mode_q <= mode_pin;
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
        por  <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (armed && !pin_s) begin
      busy  <= 1'b1;
      armed <= 1'b0;
    end else if (pin_s) begin
      armed <= 1'b1;
    end
  end

  assign rst_int = busy;
  assign mode_hw = mode_q;

  assert_release_at_end_R2: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    $fell(rst_int) |-> $past(cnt) == LAST);

  assert_window_counts_R3: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    (busy && !last) |=> (busy && cnt == CW'($past(cnt) + 1'b1)));

  assert_start_needs_low_pin_R3: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    $rose(rst_int) |-> $past(!pin_s && armed));

  assert_no_start_unarmed_R5: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    (!busy && !armed) |=> !busy);

  assert_mode_frozen_R6: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    !por |=> $stable(mode_q));

endmodule

// File: tb/test_counted_reset_seq.sv
`timescale 1ns/1ps
module test_counted_reset_seq;
  localparam int WINDOW = 1024;
  localparam int QUIET  = 1700;
  localparam int NV     = 6;
  // {first low length, gap, second low length (0 = none)}
  localparam int unsigned VEC [NV][3] = '{
    '{1, 0, 0}, '{2, 0, 0}, '{40, 0, 0}, '{1500, 0, 0},
    '{4, 20, 30}, '{10, 500, 100}
  };

  logic clk_ref = 0, pwr_good = 0, rst_pin_n = 1, mode_pin = 1;
  logic rst_int, mode_hw;
  int tests = 0, fails = 0;

  counted_reset_seq i_counted_reset_seq (
    .clk_ref(clk_ref), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n),
    .mode_pin(mode_pin), .rst_int(rst_int), .mode_hw(mode_hw));

  always #5 clk_ref = ~clk_ref;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic por_measure(input string req);
    int n = 0;
    pwr_good = 1;
    @(negedge clk_ref);
    while (rst_int && n < WINDOW + 10) begin n++; @(negedge clk_ref); end
    check(n == WINDOW - 1, req, n, WINDOW - 1);
  endtask

  task automatic ext_measure(input string rl, input string rn, output int lat, output int len);
    lat = 0; len = 0;
    do begin @(negedge clk_ref); lat++; end while (!rst_int && lat < 10);
    while (rst_int && len < WINDOW + 10) begin len++; @(negedge clk_ref); end
    check(lat == 3, rl, lat, 3);
    check(len == WINDOW, rn, len, WINDOW);
  endtask

  task automatic quiet(input int n, input string req);
    int bad = 0;
    repeat (n) begin @(negedge clk_ref); if (rst_int) bad++; end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat, len;
    repeat (4) @(negedge clk_ref);
    check(rst_int == 1, "R1 reset state rst_int", rst_int, 1);
    check(mode_hw == 0, "R6 reset state mode_hw", mode_hw, 0);

    por_measure("R2 power-on length");
    mode_pin = 0;
    repeat (5) @(negedge clk_ref);
    check(mode_hw == 1, "R6 mode captured high and frozen", mode_hw, 1);

    for (int v = 0; v < NV; v++) begin
      string rl, rn;
      rl = (v == 0) ? "R8 one-cycle pulse latency" : "R3 latency";
      rn = (VEC[v][2] != 0) ? "R4 pulse in window ignored" : (v == 0 ? "R8 length" : "R3 length");
      fork
        begin
          rst_pin_n = 0;
          repeat (VEC[v][0]) @(negedge clk_ref);
          rst_pin_n = 1;
          if (VEC[v][2] != 0) begin
            repeat (VEC[v][1]) @(negedge clk_ref);
            rst_pin_n = 0;
            repeat (VEC[v][2]) @(negedge clk_ref);
            rst_pin_n = 1;
          end
        end
        begin
          ext_measure(rl, rn, lat, len);
          quiet(QUIET, "R5 no retrigger after window");
        end
      join
    end
    check(mode_hw == 1, "R6 mode kept across pin resets", mode_hw, 1);

    // held low past the window, then a fresh edge
    rst_pin_n = 0;
    ext_measure("R3 latency", "R3 length", lat, len);
    quiet(100, "R5 held low no retrigger");
    rst_pin_n = 1;
    repeat (5) @(negedge clk_ref);
    rst_pin_n = 0;
    ext_measure("R5 fresh edge latency", "R5 fresh edge length", lat, len);
    rst_pin_n = 1;
    repeat (5) @(negedge clk_ref);

    // power loss during a pin window
    rst_pin_n = 0;
    @(negedge clk_ref);
    rst_pin_n = 1;
    repeat (100) @(negedge clk_ref);
    check(rst_int == 1, "R7 in pin window", rst_int, 1);
    pwr_good = 0;
    #1;
    check(rst_int == 1, "R1 async assert", rst_int, 1);
    @(negedge clk_ref);
    check(mode_hw == 0, "R1 mode cleared in reset", mode_hw, 0);
    mode_pin = 1;
    por_measure("R7 full power-on window");
    mode_pin = 0;
    repeat (3) @(negedge clk_ref);
    check(mode_hw == 1, "R7 mode resampled", mode_hw, 1);

    // pin held low through power-up
    pwr_good = 0;
    rst_pin_n = 0;
    @(negedge clk_ref);
    por_measure("R2 power-on with pin low");
    check(mode_hw == 0, "R6 mode captured low", mode_hw, 0);
    quiet(300, "R5 pin low at power-up no reset");
    rst_pin_n = 1;
    quiet(20, "R5 release no reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule